// File: doc/BRIEF.md
# Banked Scratchpad Read Port with Conflict Serialization

This block is the read side of a warp-wide scratchpad. The storage is split into a parameterized number of banks. Each bank word is 32 bits wide and holds two 16-bit elements. One request carries up to 32 lane element addresses and an active-lane mask. The addresses are either given flat, or computed from per-lane (row, column) tile coordinates using a configurable leading-dimension stride plus a skew (padding).

Each bank can deliver one 32-bit word per cycle. The block therefore groups the lanes into passes that have no conflicts:
- In every pass, each bank reads the word wanted by its lowest pending lane.
- Every pending lane that wants that same word is served in the same pass, whichever half it needs.

The number of passes equals the largest count of distinct words requested from any single bank. That count is returned with the data as the conflict degree, so software can judge whether its tile padding removes conflicts. A narrow one-word load port fills the banks.

Top module: `sp_scratch_read`

## Requirements
- R1: After reset, resp_valid is 0, req_ready is 1, resp_degree is 0 and resp_data is all zero.
- R2: A request is taken on a rising edge where req_valid and req_ready are both 1. req_ready then stays 0 until the edge that raises resp_valid. resp_valid is a one-cycle pulse, and req_ready is 1 in that cycle.
- R3: For an element address A of 12 bits, the bank is A[5:1] and the word within the bank is A[11:6]. A[0]=1 selects bits [31:16] of the word and A[0]=0 selects bits [15:0]. The element for lane i appears on resp_data[16*i+15:16*i].
- R4: resp_degree equals the maximum, over all banks, of the number of distinct words that active lanes address in that bank. It is 0 when no lane is active.
- R5: Lanes that address the same word of the same bank, in either half, count once toward the degree and are all served together.
- R6: resp_valid rises exactly max(D,1)+1 rising edges after the accepting edge, where D is the degree reported.
- R7: Lanes whose req_mask bit is 0 return zero data.
- R8: When req_tile is 1, lane i uses the address req_base + row_i*(cfg_stride+cfg_skew) + col_i, modulo 2^12. row_i and col_i are the 6-bit fields i of req_row and req_col. When req_tile is 0, lane i uses field i of req_addr.
- R9: A fill (fill_en=1) writes fill_data into word fill_word of bank fill_bank. Requests accepted after that edge read the new value.
- R10: Take a tile read of two rows of 16 columns (lanes 0-15 in row 0, lanes 16-31 in row 1) with base 0 and stride 128. With skew 0 it reports degree 2. With skew 16 it reports degree 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fill_en | input | 1 | Write one bank word |
| fill_bank | input | 5 | Bank to write |
| fill_word | input | 6 | Word index inside the bank |
| fill_data | input | 32 | Word value (two elements) |
| cfg_stride | input | 12 | Tile row stride in elements |
| cfg_skew | input | 12 | Padding added to the stride |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, can take a request |
| req_tile | input | 1 | 1: tile coordinates, 0: flat addresses |
| req_mask | input | 32 | Active lanes |
| req_addr | input | 384 | Flat element address per lane, 12 bits each |
| req_base | input | 12 | Tile base element address |
| req_row | input | 192 | Tile row per lane, 6 bits each |
| req_col | input | 192 | Tile column per lane, 6 bits each |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_data | output | 512 | Element per lane, 16 bits each |
| resp_degree | output | 6 | Conflict degree (pass count) |

## Verification
The assertions assume that a request is raised only while req_ready is 1. They also assume that req_valid is dropped before the next edge after acceptance, so that the latency counter in the checker starts from a single acceptance. The bench follows this rule: it raises req_valid for exactly one edge while the block is idle, then waits for resp_valid. It issues fills only between requests, so the bench's memory model never sees a fill that races with a read pass. Random addresses are drawn from narrow, same-bank and full ranges, which exercises merging, deep conflicts and ordinary mixes.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } sp_state_e;
endpackage

// File: rtl/sp_bank_ram.sv
// One bank: simple dual-port memory with registered read, BRAM friendly.
module sp_bank_ram #(
  parameter int DEPTH  = 64,
  parameter int WORD_W = 32,
  localparam int WB    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [WB-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [WB-1:0]     raddr,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/sp_addr_gen.sv
// Per-lane element address: flat, or base + row*(stride+skew) + col.
module sp_addr_gen #(
  parameter int LANES = 32,
  parameter int AW    = 12,
  parameter int RCW   = 6
) (
  input  logic                   tile,
  input  logic [AW-1:0]          base,
  input  logic [AW-1:0]          stride,
  input  logic [AW-1:0]          skew,
  input  logic [LANES*AW-1:0]    flat,
  input  logic [LANES*RCW-1:0]   row,
  input  logic [LANES*RCW-1:0]   col,
  output logic [LANES-1:0][AW-1:0] addr
);
  logic [AW-1:0] pitch;
  assign pitch = stride + skew;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [AW-1:0] row_x, col_x, tile_addr;
    assign row_x     = AW'(row[g*RCW +: RCW]);
    assign col_x     = AW'(col[g*RCW +: RCW]);
    assign tile_addr = base + row_x * pitch + col_x;
    assign addr[g]   = tile ? tile_addr : flat[g*AW +: AW];
  end
endmodule

// File: rtl/sp_pass_sched.sv
// One pass: every bank serves the word of its lowest pending lane;
// all pending lanes wanting that word are served together.
module sp_pass_sched #(
  parameter int LANES = 32,
  parameter int BANKS = 32,
  parameter int BB    = 5,
  parameter int WB    = 6
) (
  input  logic [LANES-1:0]         pending,
  input  logic [LANES-1:0][BB-1:0] lane_bank,
  input  logic [LANES-1:0][WB-1:0] lane_word,
  output logic [BANKS-1:0][WB-1:0] bank_word,
  output logic [LANES-1:0]         served
);
  always_comb begin
    bank_word = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (pending[i]) bank_word[lane_bank[i]] = lane_word[i];
    end
  end

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      served[i] = pending[i] && (lane_word[i] == bank_word[lane_bank[i]]);
    end
  end
endmodule

// File: rtl/sp_scratch_read.sv
module sp_scratch_read #(
  parameter int LANES  = 32,
  parameter int BANKS  = 32,
  parameter int DEPTH  = 64,
  parameter int ELEM_W = 16,
  parameter int RCW    = 6,
  localparam int WORD_W = 2 * ELEM_W,
  localparam int BB     = $clog2(BANKS),
  localparam int WB     = $clog2(DEPTH),
  localparam int AW     = WB + BB + 1,
  localparam int DW     = $clog2(LANES + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      fill_en,
  input  logic [BB-1:0]             fill_bank,
  input  logic [WB-1:0]             fill_word,
  input  logic [WORD_W-1:0]         fill_data,
  input  logic [AW-1:0]             cfg_stride,
  input  logic [AW-1:0]             cfg_skew,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic                      req_tile,
  input  logic [LANES-1:0]          req_mask,
  input  logic [LANES*AW-1:0]       req_addr,
  input  logic [AW-1:0]             req_base,
  input  logic [LANES*RCW-1:0]      req_row,
  input  logic [LANES*RCW-1:0]      req_col,
  output logic                      resp_valid,
  output logic [LANES*ELEM_W-1:0]   resp_data,
  output logic [DW-1:0]             resp_degree
);
  import sp_pkg::*;

  sp_state_e state;

  logic [LANES-1:0][AW-1:0]     lane_addr;
  logic [LANES-1:0][BB-1:0]     lane_bank_q;
  logic [LANES-1:0][WB-1:0]     lane_word_q;
  logic [LANES-1:0]             lane_half_q;
  logic [LANES-1:0]             pending;
  logic [LANES-1:0]             served;
  logic [LANES-1:0]             served_q;
  logic [BANKS-1:0][WB-1:0]     bank_word;
  logic [WORD_W-1:0]            rd_q [BANKS];
  logic [LANES-1:0][ELEM_W-1:0] data_q;
  logic [DW-1:0]                passes;
  logic [LANES-1:0]             left;

  sp_addr_gen #(.LANES(LANES), .AW(AW), .RCW(RCW)) u_addr (
    .tile   (req_tile),
    .base   (req_base),
    .stride (cfg_stride),
    .skew   (cfg_skew),
    .flat   (req_addr),
    .row    (req_row),
    .col    (req_col),
    .addr   (lane_addr)
  );

  sp_pass_sched #(.LANES(LANES), .BANKS(BANKS), .BB(BB), .WB(WB)) u_sched (
    .pending   (pending),
    .lane_bank (lane_bank_q),
    .lane_word (lane_word_q),
    .bank_word (bank_word),
    .served    (served)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic bank_we;
    assign bank_we = fill_en && (fill_bank == BB'(b));
    sp_bank_ram #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_ram (
      .clk   (clk),
      .we    (bank_we),
      .waddr (fill_word),
      .wdata (fill_data),
      .raddr (bank_word[b]),
      .rdata (rd_q[b])
    );
  end

  assign left      = pending & ~served;
  assign req_ready = (state == ST_IDLE);
  assign resp_data = data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      pending     <= '0;
      served_q    <= '0;
      passes      <= '0;
      resp_valid  <= 1'b0;
      resp_degree <= '0;
      data_q      <= '0;
    end else begin
      resp_valid <= 1'b0;
      served_q   <= '0;
      for (int i = 0; i < LANES; i++) begin
        if (served_q[i]) begin
          data_q[i] <= lane_half_q[i] ? rd_q[lane_bank_q[i]][WORD_W-1:ELEM_W]
                                      : rd_q[lane_bank_q[i]][ELEM_W-1:0];
        end
      end
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            for (int i = 0; i < LANES; i++) begin
              lane_half_q[i] <= lane_addr[i][0];
              lane_bank_q[i] <= lane_addr[i][BB:1];
              lane_word_q[i] <= lane_addr[i][AW-1:BB+1];
            end
            pending <= req_mask;
            passes  <= '0;
            data_q  <= '0;
            state   <= ST_RUN;
          end
        end
        ST_RUN: begin
          served_q <= served;
          pending  <= left;
          if (|pending) passes <= passes + DW'(1);
          if (left == '0) state <= ST_DRAIN;
        end
        ST_DRAIN: begin
          resp_valid  <= 1'b1;
          resp_degree <= passes;
          state       <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sp_scratch_read_chk.sv
module sp_scratch_read_chk #(
  parameter int LANES = 32,
  parameter int DW    = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic [LANES-1:0] req_mask,
  input logic             resp_valid,
  input logic [DW-1:0]    resp_degree
);
  logic [DW:0]   edge_cnt;
  logic [DW-1:0] act_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      edge_cnt <= '0;
      act_cnt  <= '0;
    end else if (req_valid && req_ready) begin
      edge_cnt <= '0;
      act_cnt  <= DW'($countones(req_mask));
    end else if (!req_ready) begin
      edge_cnt <= edge_cnt + (DW+1)'(1);
    end
  end

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready); // R2
  AST_READY_WITH_RESP: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> req_ready); // R2
  AST_RESP_ONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> !resp_valid); // R2
  AST_DEGREE_BOUND: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> resp_degree <= act_cnt); // R4
  AST_LATENCY_MATCH: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> edge_cnt == ((resp_degree == '0) ? (DW+1)'(2)
                                 : (DW+1)'(resp_degree) + (DW+1)'(1))); // R6
endmodule

bind sp_scratch_read sp_scratch_read_chk #(.LANES(LANES), .DW(DW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_mask    (req_mask),
  .resp_valid  (resp_valid),
  .resp_degree (resp_degree)
);

// File: tb/sp_scratch_read_test.sv
`timescale 1ns/1ps
module sp_scratch_read_test;
  logic         clk = 1'b0;
  logic         rst;
  logic         fill_en;
  logic [4:0]   fill_bank;
  logic [5:0]   fill_word;
  logic [31:0]  fill_data;
  logic [11:0]  cfg_stride, cfg_skew;
  logic         req_valid, req_ready, req_tile;
  logic [31:0]  req_mask;
  logic [383:0] req_addr;
  logic [11:0]  req_base;
  logic [191:0] req_row, req_col;
  logic         resp_valid;
  logic [511:0] resp_data;
  logic [5:0]   resp_degree;

  int tests = 0, fails = 0;
  bit done = 0;

  logic [31:0] shadow [32][64];
  logic [11:0] fl [32];
  logic [5:0]  rw [32], cl [32];

  always #2 clk = ~clk;

  sp_scratch_read uut (
    .clk(clk), .rst(rst), .fill_en(fill_en), .fill_bank(fill_bank),
    .fill_word(fill_word), .fill_data(fill_data), .cfg_stride(cfg_stride),
    .cfg_skew(cfg_skew), .req_valid(req_valid), .req_ready(req_ready),
    .req_tile(req_tile), .req_mask(req_mask), .req_addr(req_addr),
    .req_base(req_base), .req_row(req_row), .req_col(req_col),
    .resp_valid(resp_valid), .resp_data(resp_data), .resp_degree(resp_degree)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic fill(input int b, input int w, input logic [31:0] d);
    @(negedge clk);
    fill_en = 1; fill_bank = 5'(b); fill_word = 6'(w); fill_data = d;
    shadow[b][w] = d;
    @(negedge clk);
    fill_en = 0;
  endtask

  task automatic run_req(input bit tile, input logic [31:0] mask, input string rq,
                         input int exp_deg_forced);
    logic [11:0] ea [32];
    int deg, edges, want;
    bit mism;
    int bad_lane;
    logic [15:0] exp_e, act_e;
    for (int i = 0; i < 32; i++)
      ea[i] = tile ? 12'(req_base + 12'(rw[i]) * (cfg_stride + cfg_skew) + 12'(cl[i])) : fl[i];
    deg = 0;
    for (int b = 0; b < 32; b++) begin
      int c = 0;
      for (int i = 0; i < 32; i++) begin
        if (mask[i] && ea[i][5:1] == 5'(b)) begin
          bit nw = 1;
          for (int j = 0; j < i; j++)
            if (mask[j] && ea[j][11:1] == ea[i][11:1]) nw = 0;
          if (nw) c++;
        end
      end
      if (c > deg) deg = c;
    end
    if (exp_deg_forced >= 0)
      chk(deg == exp_deg_forced, rq, "bench model degree", deg, exp_deg_forced);
    @(negedge clk);
    req_valid = 1; req_tile = tile; req_mask = mask;
    for (int i = 0; i < 32; i++) begin
      req_addr[i*12 +: 12] = fl[i];
      req_row[i*6 +: 6] = rw[i];
      req_col[i*6 +: 6] = cl[i];
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    chk(req_ready == 0, "R2", "ready low after accept", req_ready, 0);
    edges = 0;
    while (!resp_valid && edges < 100) begin
      @(posedge clk); edges++;
      @(negedge clk);
    end
    want = (deg == 0 ? 1 : deg) + 1;
    chk(edges == want, "R6", "response latency edges", edges, want);
    chk(resp_degree == 6'(deg), rq, "conflict degree (R4)", resp_degree, deg);
    chk(req_ready == 1, "R2", "ready with response", req_ready, 1);
    mism = 0; bad_lane = 0; exp_e = 0; act_e = 0;
    for (int i = 0; i < 32; i++) begin
      logic [15:0] e;
      logic [31:0] w = shadow[ea[i][5:1]][ea[i][11:6]];
      e = !mask[i] ? 16'h0 : (ea[i][0] ? w[31:16] : w[15:0]);
      if (!mism && resp_data[i*16 +: 16] !== e) begin
        mism = 1; bad_lane = i; exp_e = e; act_e = resp_data[i*16 +: 16];
      end
    end
    chk(!mism, rq, $sformatf("lane data (R3/R7) lane %0d", bad_lane), act_e, exp_e);
    @(negedge clk);
    chk(resp_valid == 0, "R2", "response one-cycle pulse", resp_valid, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    rst = 1; fill_en = 0; fill_bank = 0; fill_word = 0; fill_data = 0;
    cfg_stride = 0; cfg_skew = 0; req_valid = 0; req_tile = 0; req_mask = 0;
    req_addr = 0; req_base = 0; req_row = 0; req_col = 0;
    for (int i = 0; i < 32; i++) begin fl[i] = 0; rw[i] = 0; cl[i] = 0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(resp_valid == 0, "R1", "resp_valid after reset", resp_valid, 0);
    chk(req_ready == 1, "R1", "req_ready after reset", req_ready, 1);
    chk(resp_degree == 0, "R1", "degree after reset", resp_degree, 0);
    chk(resp_data == 0, "R1", "data after reset", resp_data[63:0], 0);
    rst = 0;
    for (int b = 0; b < 32; b++)
      for (int w = 0; w < 64; w++) begin
        @(negedge clk);
        fill_en = 1; fill_bank = 5'(b); fill_word = 6'(w);
        fill_data = $urandom; shadow[b][w] = fill_data;
      end
    @(negedge clk); fill_en = 0;

    // R5: all lanes one element -> degree 1
    for (int i = 0; i < 32; i++) fl[i] = 12'h2A7;
    run_req(0, 32'hFFFF_FFFF, "R5", 1);
    // R3/R5: consecutive elements, pairs share a word
    for (int i = 0; i < 32; i++) fl[i] = 12'(i);
    run_req(0, 32'hFFFF_FFFF, "R3", 1);
    // R4: same bank, 32 distinct words -> degree 32
    for (int i = 0; i < 32; i++) fl[i] = 12'(i * 64 + 2);
    run_req(0, 32'hFFFF_FFFF, "R4", 32);
    // R7/R4: no active lane
    run_req(0, 32'h0, "R7", 0);
    // R7: partial mask
    run_req(0, 32'h8000_0001, "R7", 2);
    // R10/R8: two tile rows, skew 0 then 16
    req_base = 0; cfg_stride = 12'd128; cfg_skew = 0;
    for (int i = 0; i < 32; i++) begin rw[i] = 6'(i / 16); cl[i] = 6'(i % 16); end
    run_req(1, 32'hFFFF_FFFF, "R10", 2);
    cfg_skew = 12'd16;
    run_req(1, 32'hFFFF_FFFF, "R10", 1);
    // R9: fill then read back both halves
    fill(3, 5, 32'hCAFE_BEEF);
    fl[0] = 12'd327; fl[1] = 12'd326;
    run_req(0, 32'h0000_0003, "R9", 1);

    // random mix
    for (int n = 0; n < 200; n++) begin
      int kind = $urandom % 4;
      logic [31:0] m = ($urandom % 5 == 0) ? 32'hFFFF_FFFF : $urandom;
      if (kind == 3) begin
        logic [11:0] st [4] = '{12'd64, 12'd128, 12'd256, 12'd96};
        logic [11:0] sk [4] = '{12'd0, 12'd8, 12'd16, 12'd2};
        req_base = 12'($urandom); cfg_stride = st[$urandom % 4]; cfg_skew = sk[$urandom % 4];
        for (int i = 0; i < 32; i++) begin rw[i] = 6'($urandom % 16); cl[i] = 6'($urandom % 16); end
        run_req(1, m, "R8", -1);
      end else begin
        for (int i = 0; i < 32; i++) begin
          logic [11:0] r = 12'($urandom);
          fl[i] = (kind == 0) ? r : (kind == 1) ? (r & 12'h07F) : {r[11:6], 5'd9, r[0]};
        end
        run_req(0, m, "R4", -1);
      end
      if (n % 50 == 0) begin
        int b = $urandom % 32, w = $urandom % 64;
        fill(b, w, $urandom);
      end
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule